// File: doc/BRIEF.md
# Sixteen-Line GPIO and Control Register Block

This block is a small bank of 16-bit registers behind a simple memory-mapped bus (valid, write, address, write data, registered read data). Most of the bank is plain storage that software reads back: a mode word, a data word, a control word, and three interrupt-related words (request, mask, status). These words only hold values. A read-only status word comes out of reset as 0x0002. A power word adds one side effect on writes: when bit 7 of the written value is set, bits 15 and 6 are also set.

The GPIO part has a direction register and a level register. The sixteen output pins carry the level gated by the direction. The bus writes the level through either of two offsets, and each such write is masked by the current direction. External inputs can set or clear single level bits directly. After every bus write to the direction or level register, the block compares the new gated vector with the vector it recorded at the previous such write. It then pulses a one-cycle strobe on each line that differs, and presents the new gated vector next to the strobe.

Top module: `gpio_ctl_regs`

## Requirements
- R1: After reset, a read of the status word (word index 2, byte offset 0x08) returns 0x0002. Every other register reads 0, and `gpio_out`, `chg_strobe` and `chg_level` are 0.
- R2: Word indices taken from address bits [11:2] select mode=0, data=1, status=2, power=3, control=4, interrupt request=5, interrupt mask=6, interrupt status=7, direction=8, level-write=9, level-read=10. A write stores bits [15:0] of the write data and discards the upper bits. The mode, data, control, interrupt request, mask and status words and the direction word read back exactly what was stored.
- R3: Read data appears on `bus_rdata` in the cycle after the read request and then holds until the next read. Address bits [1:0] take no part in the decode.
- R4: Bus writes to the status word have no effect. It always reads 0x0002.
- R5: A write to the power word stores the truncated value. If bit 7 of that value is 1, bits 15 and 6 are also stored as 1.
- R6: A bus write at word index 9 or 10 stores the value ANDed with the current direction register. Reads at either index return the level register.
- R7: `gpio_out` always equals the level register ANDed with the direction register.
- R8: In the cycle after a bus write to the direction or level register, `chg_strobe` has a 1 on each line whose new gated level differs from the vector recorded at the previous such write, and `chg_level` shows the new gated vector. In every other cycle `chg_strobe` is 0.
- R9: When `ext_we[n]` is 1, level bit n takes `ext_val[n]`, whatever the direction. This produces no strobe. If a bus level write happens in the same cycle, the bus value wins for all bits.
- R10: A read at word indices 11 to 1023 returns 0. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data; only bits [15:0] are stored |
| bus_rdata | output | 16 | Registered read data |
| ext_we | input | 16 | Per-line external level update enable |
| ext_val | input | 16 | Per-line external level value |
| gpio_out | output | 16 | Level gated by direction |
| chg_strobe | output | 16 | One-cycle per-line change pulse |
| chg_level | output | 16 | Gated vector recorded at the last direction or level write |

## Verification
The bench walks long pseudo-random sequences of direction and level writes and predicts every strobe from the recorded previous vector. A design that compared against the live pins instead would emit spurious pulses, or miss pulses, after external inputs moved the level. It checks that a direction write neither re-masks nor clears the stored level, that power writes with bit 7 set also raise bits 15 and 6, that a same-cycle external update loses to a bus level write, and that status ignores writes. It reads every word index in the 4 KB window, so a decoder that aliases, or that decodes the byte-lane bits, returns nonzero data where zero is expected.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
    localparam int REG_W = 16;
    localparam int LAST_IDX = 10;
    localparam int PWR_TRIG_BIT = 7;
    localparam logic [REG_W-1:0] STAT_INIT = 16'h0002;
    localparam logic [REG_W-1:0] PWR_FORCE = 16'h8040;

    typedef enum logic [3:0] {
        RG_MODE  = 4'd0,
        RG_DATA  = 4'd1,
        RG_STAT  = 4'd2,
        RG_PWR   = 4'd3,
        RG_CTL   = 4'd4,
        RG_IRQ   = 4'd5,
        RG_IMASK = 4'd6,
        RG_ISTAT = 4'd7,
        RG_DIR   = 4'd8,
        RG_LVLW  = 4'd9,
        RG_LVLR  = 4'd10,
        RG_NONE  = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_sel_e         sel;
        logic [REG_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic [REG_W-1:0] mode;
        logic [REG_W-1:0] data;
        logic [REG_W-1:0] pwr;
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] irq;
        logic [REG_W-1:0] imask;
        logic [REG_W-1:0] istat;
    } ctl_bank_t;

    function automatic logic [REG_W-1:0] pwr_value(input logic [REG_W-1:0] v);
        return v[PWR_TRIG_BIT] ? (v | PWR_FORCE) : v;
    endfunction

    function automatic logic is_lvl_sel(input reg_sel_e s);
        return (s == RG_LVLW) || (s == RG_LVLR);
    endfunction

    function automatic logic is_gpio_sel(input reg_sel_e s);
        return (s == RG_DIR) || is_lvl_sel(s);
    endfunction
endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
    import gcr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_req_t          req
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             unused_lanes;

    assign idx          = bus_addr[ADDR_W-1:2];
    assign unused_lanes = ^{bus_addr[1:0], bus_wdata[DATA_W-1:REG_W]};

    always_comb begin
        req.wr   = bus_valid && bus_write;
        req.rd   = bus_valid && !bus_write;
        req.data = bus_wdata[REG_W-1:0];
        if (idx <= IDX_W'(LAST_IDX))
            req.sel = reg_sel_e'(idx[3:0]);
        else
            req.sel = RG_NONE;
    end
endmodule

// File: rtl/gcr_ctl_bank.sv
module gcr_ctl_bank
    import gcr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_req_t  req,
    output ctl_bank_t bank
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
        end else if (req.wr) begin
            case (req.sel)
                RG_MODE:  bank.mode  <= req.data;
                RG_DATA:  bank.data  <= req.data;
                RG_PWR:   bank.pwr   <= pwr_value(req.data);
                RG_CTL:   bank.ctl   <= req.data;
                RG_IRQ:   bank.irq   <= req.data;
                RG_IMASK: bank.imask <= req.data;
                RG_ISTAT: bank.istat <= req.data;
                default:  ;
            endcase
        end
    end

    // R5: power write with trigger bit raises the forced bits
    a_r5_power_force: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == RG_PWR && req.data[PWR_TRIG_BIT])
        |=> (bank.pwr[15] && bank.pwr[6]));

    // R10: unmapped write leaves the bank untouched
    a_r10_unmapped_hold: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == RG_NONE) |=> $stable(bank));
endmodule

// File: rtl/gcr_gpio.sv
module gcr_gpio
    import gcr_pkg::*;
#(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [N_LINES-1:0] ext_we,
    input  logic [N_LINES-1:0] ext_val,
    output logic [N_LINES-1:0] dir_q,
    output logic [N_LINES-1:0] lvl_q,
    output logic [N_LINES-1:0] gpio_out,
    output logic [N_LINES-1:0] chg_strobe,
    output logic [N_LINES-1:0] chg_level
);
    logic [N_LINES-1:0] ext_merge;
    logic [N_LINES-1:0] lvl_next;
    logic [N_LINES-1:0] dir_next;
    logic [N_LINES-1:0] out_next;
    logic [N_LINES-1:0] prev_q;
    logic               gpio_wr;
    logic               lvl_wr;
    logic               dir_wr;

    assign lvl_wr  = req.wr && is_lvl_sel(req.sel);
    assign dir_wr  = req.wr && (req.sel == RG_DIR);
    assign gpio_wr = lvl_wr || dir_wr;

    for (genvar n = 0; n < N_LINES; n++) begin : g_line
        assign ext_merge[n] = ext_we[n] ? ext_val[n] : lvl_q[n];
    end

    always_comb begin
        lvl_next = lvl_wr ? (req.data[N_LINES-1:0] & dir_q) : ext_merge;
        dir_next = dir_wr ? req.data[N_LINES-1:0] : dir_q;
        out_next = lvl_next & dir_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q      <= '0;
            lvl_q      <= '0;
            prev_q     <= '0;
            chg_strobe <= '0;
        end else begin
            dir_q <= dir_next;
            lvl_q <= lvl_next;
            if (gpio_wr) begin
                chg_strobe <= prev_q ^ out_next;
                prev_q     <= out_next;
            end else begin
                chg_strobe <= '0;
            end
        end
    end

    assign gpio_out  = lvl_q & dir_q;
    assign chg_level = prev_q;

    // R6: stored level never has bits outside the direction right after a level write
    a_r6_lvl_masked: assert property (@(posedge clk) disable iff (rst)
        lvl_wr |=> ((lvl_q & ~dir_q) == '0));

    // R8: a strobe only follows a direction or level write
    a_r8_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        (chg_strobe != '0) |-> $past(gpio_wr));

    // R8: without external activity the reported vector matches the pins
    a_r8_level_matches_pins: assert property (@(posedge clk) disable iff (rst)
        (gpio_wr && ext_we == '0) |=> (chg_level == gpio_out));

    // R9: external updates alone raise no strobe
    a_r9_ext_silent: assert property (@(posedge clk) disable iff (rst)
        (!gpio_wr && ext_we != '0) |=> (chg_strobe == '0));
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
    import gcr_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [N_LINES-1:0] ext_we,
    input  logic [N_LINES-1:0] ext_val,
    output logic [N_LINES-1:0] gpio_out,
    output logic [N_LINES-1:0] chg_strobe,
    output logic [N_LINES-1:0] chg_level
);
    bus_req_t           req;
    ctl_bank_t          bank;
    logic [N_LINES-1:0] dir_q;
    logic [N_LINES-1:0] lvl_q;
    logic [REG_W-1:0]   rd_val;

    gcr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req       (req)
    );

    gcr_ctl_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .bank (bank)
    );

    gcr_gpio #(.N_LINES(N_LINES)) u_gpio (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .ext_we     (ext_we),
        .ext_val    (ext_val),
        .dir_q      (dir_q),
        .lvl_q      (lvl_q),
        .gpio_out   (gpio_out),
        .chg_strobe (chg_strobe),
        .chg_level  (chg_level)
    );

    always_comb begin
        case (req.sel)
            RG_MODE:  rd_val = bank.mode;
            RG_DATA:  rd_val = bank.data;
            RG_STAT:  rd_val = STAT_INIT;
            RG_PWR:   rd_val = bank.pwr;
            RG_CTL:   rd_val = bank.ctl;
            RG_IRQ:   rd_val = bank.irq;
            RG_IMASK: rd_val = bank.imask;
            RG_ISTAT: rd_val = bank.istat;
            RG_DIR:   rd_val = REG_W'(dir_q);
            RG_LVLW,
            RG_LVLR:  rd_val = REG_W'(lvl_q);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (req.rd)
            bus_rdata <= rd_val;
    end

    // R4: status always reads its fixed value
    a_r4_status_fixed: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.sel == RG_STAT) |=> (bus_rdata == STAT_INIT));

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.sel == RG_NONE) |=> (bus_rdata == '0));

    // R3: read data holds when no read is requested
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !req.rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_gpio_ctl_regs.sv
module sim_gpio_ctl_regs;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [15:0] ext_we, ext_val;
    logic [15:0] gpio_out, chg_strobe, chg_level;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_ctl_regs u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_we(ext_we), .ext_val(ext_val), .gpio_out(gpio_out),
        .chg_strobe(chg_strobe), .chg_level(chg_level)
    );

    logic [15:0] m_mode, m_data, m_pwr, m_ctl, m_irq, m_imask, m_istat;
    logic [15:0] m_dir, m_lvl, m_prev, m_strobe;
    logic [15:0] seed = 16'hACE1;

    function automatic logic [15:0] nxt(input logic [15:0] s);
        logic [15:0] x = s;
        x = x ^ (x << 7);
        x = x ^ (x >> 9);
        x = x ^ (x << 8);
        return (x == 0) ? 16'h1 : x;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mdl_read(input logic [11:0] a);
        case (a[11:2])
            10'd0:  return m_mode;
            10'd1:  return m_data;
            10'd2:  return 16'h0002;
            10'd3:  return m_pwr;
            10'd4:  return m_ctl;
            10'd5:  return m_irq;
            10'd6:  return m_imask;
            10'd7:  return m_istat;
            10'd8:  return m_dir;
            10'd9,
            10'd10: return m_lvl;
            default: return 16'h0;
        endcase
    endfunction

    task automatic mdl_write(input logic [11:0] a, input logic [31:0] d);
        logic [15:0] v = d[15:0];
        logic        g = 1'b0;
        case (a[11:2])
            10'd0: m_mode = v;
            10'd1: m_data = v;
            10'd3: m_pwr  = v[7] ? (v | 16'h8040) : v;
            10'd4: m_ctl  = v;
            10'd5: m_irq  = v;
            10'd6: m_imask = v;
            10'd7: m_istat = v;
            10'd8: begin m_dir = v; g = 1'b1; end
            10'd9, 10'd10: begin m_lvl = v & m_dir; g = 1'b1; end
            default: ;
        endcase
        if (g) begin
            m_strobe = m_prev ^ (m_lvl & m_dir);
            m_prev   = m_lvl & m_dir;
        end else begin
            m_strobe = 16'h0;
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        mdl_write(a, d);
        @(negedge clk);
        bus_valid = 1'b0;
        chk(chg_strobe == m_strobe, "R8 strobe", chg_strobe, m_strobe);
        chk(chg_level == m_prev, "R8 level", chg_level, m_prev);
        chk(gpio_out == (m_lvl & m_dir), "R7 gpio_out", gpio_out, m_lvl & m_dir);
    endtask

    task automatic bus_rd(input logic [11:0] a, input string req);
        logic [15:0] e;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        e = mdl_read(a);
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        chk(bus_rdata == e, req, bus_rdata, e);
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i <= 10; i++) bus_rd(12'(i << 2), req);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_mode = 0; m_data = 0; m_pwr = 0; m_ctl = 0; m_irq = 0; m_imask = 0;
        m_istat = 0; m_dir = 0; m_lvl = 0; m_prev = 0; m_strobe = 0;
        rst = 1'b1; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
        ext_we = 0; ext_val = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(gpio_out == 0 && chg_strobe == 0 && chg_level == 0, "R1 outputs", {gpio_out, chg_strobe}, 0);
        read_all("R1 reset read");

        // R2 plain storage with upper-bit truncation
        for (int k = 0; k < 24; k++) begin
            for (int i = 0; i <= 8; i++) begin
                if (i == 2 || i == 3) continue;
                seed = nxt(seed);
                bus_wr(12'(i << 2), {~seed, seed});
                bus_rd(12'(i << 2), "R2 readback");
            end
        end

        // R5 power: exhaustive over low byte with varied high byte
        for (int v = 0; v < 256; v++) begin
            bus_wr(12'h00C, {16'hFFFF, 8'(v * 37), 8'(v)});
            bus_rd(12'h00C, "R5 power");
        end

        // R4 status ignores writes
        bus_wr(12'h008, 32'h0000_FFFD);
        bus_rd(12'h008, "R4 status");
        bus_wr(12'h008, 32'h0000_0000);
        bus_rd(12'h008, "R4 status");

        // R3 byte-lane bits ignored and read data holds
        for (int i = 0; i <= 10; i++) bus_rd(12'((i << 2) | 3), "R3 lane bits");
        repeat (3) @(negedge clk);
        chk(bus_rdata == m_lvl, "R3 hold", bus_rdata, m_lvl);

        // R10 unmapped writes change nothing, unmapped reads are zero
        bus_wr(12'h02C, 32'hFFFF_FFFF);
        bus_wr(12'h400, 32'h1234_5678);
        bus_wr(12'hFFC, 32'hFFFF_FFFF);
        read_all("R10 after unmapped write");
        for (int i = 11; i < 1024; i++) bus_rd(12'(i << 2), "R10 unmapped read");

        // R6 R8 random direction/level sequences
        for (int k = 0; k < 400; k++) begin
            seed = nxt(seed);
            case (seed[1:0])
                2'd0: bus_wr(12'h020, {16'h0, nxt(seed)});
                2'd1: bus_wr(12'h024, {16'hABCD, nxt(seed)});
                default: bus_wr(12'h028, {16'h0, nxt(seed)});
            endcase
            if (seed[3]) bus_rd(seed[2] ? 12'h028 : 12'h024, "R6 level read");
            // strobe must be gone one cycle later
            @(negedge clk);
            chk(chg_strobe == 0, "R8 single cycle", chg_strobe, 0);
        end

        // R6 direction write does not re-mask level
        bus_wr(12'h020, 32'hFFFF);
        bus_wr(12'h024, 32'h5A5A);
        bus_wr(12'h020, 32'h00FF);
        bus_rd(12'h024, "R6 level kept");
        bus_wr(12'h020, 32'hFFFF);
        bus_rd(12'h028, "R6 level kept");

        // R9 external inputs: no strobe, direction independent
        bus_wr(12'h020, 32'h0F0F);
        for (int k = 0; k < 64; k++) begin
            seed = nxt(seed);
            @(negedge clk);
            ext_we = seed; ext_val = nxt(seed);
            @(posedge clk);
            m_lvl = (m_lvl & ~ext_we) | (ext_val & ext_we);
            @(negedge clk);
            ext_we = 0;
            chk(chg_strobe == 0, "R9 no strobe", chg_strobe, 0);
            chk(gpio_out == (m_lvl & m_dir), "R9 gpio_out", gpio_out, m_lvl & m_dir);
            bus_rd(12'h028, "R9 level");
        end
        // next bus write compares against recorded vector, not pins
        bus_wr(12'h020, 32'hFFFF);

        // R9 collision: bus level write wins
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 12'h024; bus_wdata = 32'h00F0;
        ext_we = 16'hFFFF; ext_val = 16'hFF0F;
        @(posedge clk);
        mdl_write(12'h024, 32'h00F0);
        @(negedge clk);
        bus_valid = 0; ext_we = 0;
        chk(chg_strobe == m_strobe, "R9 collision strobe", chg_strobe, m_strobe);
        bus_rd(12'h024, "R9 collision level");

        // R1 reset again clears everything
        @(negedge clk); rst = 1;
        @(posedge clk); @(negedge clk); rst = 0;
        m_mode = 0; m_data = 0; m_pwr = 0; m_ctl = 0; m_irq = 0; m_imask = 0;
        m_istat = 0; m_dir = 0; m_lvl = 0; m_prev = 0;
        chk(gpio_out == 0 && chg_level == 0, "R1 re-reset", {gpio_out, chg_level}, 0);
        read_all("R1 re-reset read");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule